// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from 52 peripheral channels plus one non-maskable watchdog source. It keeps each request in its own flag and gives every channel a 3-bit level. Each cycle, purely combinationally, it selects the single most urgent pending request. If that request's level passes an acceptance test against a 3-bit CPU mask, the block presents the level and vector to the CPU. Vector numbers are fixed: channel `i` uses vector `i+1`, and the watchdog source uses vector 0.

When the CPU acknowledges, the block clears the request flag of the presented vector. It raises the mask to one above the accepted level and pushes the old mask onto an eight-entry save stack. A return-from-interrupt strobe pops the saved mask back. Eight start-vector slots can redirect a chosen vector to a DMA-request output instead of the CPU. A small byte-wide register bus holds the priorities (with read-only flag status), the start-vector slots and a write-only clear register.

Top module: `prio_intc`

## Requirements
- R1: A pulse on `irqPulse[i]` sets the flag of vector i+1. Register address k (0..25) holds channel 2k in bits [2:0], with its flag in bit 3, and channel 2k+1 in bits [6:4], with its flag in bit 7. Flag bits read back status only, and writing them has no effect.
- R2: A channel whose level is 0 or 7 still latches its flag but never takes part in selection.
- R3: The highest level wins the selection, and a tie goes to the lowest vector. The watchdog source (`nmiPulse`, vector 0) always has level 7. `cpuLevel` and `cpuVector` read 0 while `cpuReq` is low.
- R4: `cpuReq` is high only when the selected level is at least `cpuMask`, or is 7. After reset `cpuMask` is 0.
- R5: `cpuAck` while `cpuReq` is high clears the flag of the presented vector. In the same step it sets `cpuMask` to the accepted level plus one (saturating at 7) and saves the previous mask.
- R6: `cpuReti` without an effective acknowledge restores the most recently saved mask. With an empty stack the mask is left unchanged.
- R7: The save stack holds 8 entries. A push onto a full stack stores nothing and sets `stackErr`, which stays set until reset. The mask is still raised.
- R8: Addresses 32..39 hold eight 6-bit start vectors, and 0 means an unused slot. A selected vector that matches a slot drives `dmaReq` and `dmaVector` instead of `cpuReq`, regardless of the mask. `dmaAck` while `dmaReq` is high clears that flag.
- R9: `dmaEnd` clears the flag of `dmaEndVec`. A write to address 40 clears the flag of the vector in `regWdata[5:0]`. Vectors above 52 are ignored.
- R10: A new pulse on a channel in the same cycle as any clear of that channel leaves the flag set.
- R11: After reset all flags, levels and slots are 0, the stack is empty and `stackErr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPulse | input | 52 | Peripheral request pulses, bit i for vector i+1 |
| nmiPulse | input | 1 | Watchdog request pulse, vector 0 |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| cpuReq | output | 1 | Request to the CPU |
| cpuLevel | output | 3 | Level of the presented request |
| cpuVector | output | 6 | Vector of the presented request |
| cpuAck | input | 1 | CPU acknowledge of the presented vector |
| cpuReti | input | 1 | Return-from-interrupt strobe |
| cpuMask | output | 3 | Current acceptance mask |
| stackErr | output | 1 | Sticky save-stack overflow |
| dmaReq | output | 1 | Request routed to DMA |
| dmaVector | output | 6 | Vector of the DMA request |
| dmaAck | input | 1 | DMA acceptance of the presented vector |
| dmaEnd | input | 1 | DMA burst end strobe |
| dmaEndVec | input | 6 | Vector whose flag the burst end clears |

## Verification
The hardest situation to reach is a save-stack overflow followed by a full unwind. Getting there takes nine nested acceptances while the mask sits at 7, and only the level-7 watchdog source can still get through at that point. A directed sequence therefore pulses the watchdog source and acknowledges it nine times, then issues retire strobes until the original mask reappears. The race between a fresh pulse and an acknowledge clear on the same channel is also forced directly. Long random runs then mix pulses, priority and slot rewrites, clears and strobes, so that mask nesting, DMA redirection and tie-breaks all interleave.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NUM_CH    = 52;
  localparam int VEC_W     = $clog2(NUM_CH + 1);
  localparam int LVL_W     = 3;
  localparam int NUM_DMA   = 8;
  localparam int STK_DEPTH = 8;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int DMA_BASE  = 32;
  localparam int CLR_ADDR  = 40;

  typedef struct packed {
    logic cpuClr;
    logic dmaClr;
  } strobe_t;
endpackage

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqPulse,
  input  logic              nmiPulse,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              dmaEnd,
  input  logic [VEC_W-1:0]  dmaEndVec,
  input  strobe_t           strobes,
  output logic              winValid,
  output logic [LVL_W-1:0]  winLevel,
  output logic [VEC_W-1:0]  winVec,
  output logic              winIsDma
);
  localparam int NUM_VEC   = NUM_CH + 1;
  localparam int PRIO_REGS = (NUM_CH + 1) / 2;
  localparam int HALF      = DATA_W / 2;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [NUM_VEC-1:0] flags;
  logic [NUM_VEC-1:0] clrMask;
  logic [LVL_W-1:0]   prio [NUM_CH];
  logic [VEC_W-1:0]   slot [NUM_DMA];
  logic               clrWr;

  assign clrWr = regWe && (regAddr == ADDR_W'(CLR_ADDR));

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      clrMask[v] = ((strobes.cpuClr || strobes.dmaClr) && winVec == VEC_W'(v))
                || (dmaEnd && dmaEndVec == VEC_W'(v))
                || (clrWr && regWdata[VEC_W-1:0] == VEC_W'(v));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | {irqPulse, nmiPulse};
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_prio
    localparam int LO = (c % 2 == 1) ? HALF : 0;
    always_ff @(posedge clk) begin
      if (!rstN) prio[c] <= '0;
      else if (regWe && regAddr == ADDR_W'(c / 2))
        prio[c] <= regWdata[LO +: LVL_W];
    end
  end

  for (genvar s = 0; s < NUM_DMA; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) slot[s] <= '0;
      else if (regWe && regAddr == ADDR_W'(DMA_BASE + s))
        slot[s] <= regWdata[VEC_W-1:0];
    end
  end

  always_comb begin
    logic [LVL_W-1:0] lvl;
    winValid = flags[0];
    winLevel = flags[0] ? LVL_MAX : '0;
    winVec   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      lvl = prio[c];
      if (flags[c+1] && lvl != '0 && lvl != LVL_MAX && lvl > winLevel) begin
        winValid = 1'b1;
        winLevel = lvl;
        winVec   = VEC_W'(c + 1);
      end
    end
  end

  always_comb begin
    winIsDma = 1'b0;
    for (int s = 0; s < NUM_DMA; s++) begin
      if (winValid && slot[s] != '0 && slot[s] == winVec) winIsDma = 1'b1;
    end
  end

  always_comb begin
    int idx;
    regRdata = '0;
    idx = int'(regAddr);
    if (idx < PRIO_REGS) begin
      regRdata[LVL_W-1:0] = prio[2*idx];
      regRdata[HALF-1]    = flags[2*idx+1];
      if (2*idx + 1 < NUM_CH) begin
        regRdata[HALF +: LVL_W] = prio[2*idx+1];
        regRdata[DATA_W-1]      = flags[2*idx+2];
      end
    end else if (idx >= DMA_BASE && idx < DMA_BASE + NUM_DMA) begin
      regRdata[VEC_W-1:0] = slot[idx-DMA_BASE];
    end
  end
endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             winValid,
  input  logic [LVL_W-1:0] winLevel,
  input  logic             winIsDma,
  input  logic             cpuAck,
  input  logic             cpuReti,
  input  logic             dmaAck,
  output logic             cpuReq,
  output logic             dmaReq,
  output logic [LVL_W-1:0] cpuMask,
  output logic             stackErr,
  output strobe_t          strobes
);
  localparam int DEP_W = $clog2(STK_DEPTH + 1);
  localparam int IDX_W = $clog2(STK_DEPTH);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [LVL_W-1:0] stack [STK_DEPTH];
  logic [DEP_W-1:0] depth;
  logic [DEP_W-1:0] depthM1;
  logic [LVL_W-1:0] raised;
  logic             take;

  assign cpuReq  = winValid && !winIsDma && (winLevel >= cpuMask || winLevel == LVL_MAX);
  assign dmaReq  = winValid && winIsDma;
  assign take    = cpuAck && cpuReq;
  assign raised  = (winLevel == LVL_MAX) ? LVL_MAX : winLevel + 1'b1;
  assign depthM1 = depth - 1'b1;

  assign strobes.cpuClr = take;
  assign strobes.dmaClr = dmaAck && dmaReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuMask  <= '0;
      depth    <= '0;
      stackErr <= 1'b0;
    end else if (take) begin
      cpuMask <= raised;
      if (depth < DEP_W'(STK_DEPTH)) begin
        stack[depth[IDX_W-1:0]] <= cpuMask;
        depth <= depth + 1'b1;
      end else begin
        stackErr <= 1'b1;
      end
    end else if (cpuReti && depth != '0) begin
      cpuMask <= stack[depthM1[IDX_W-1:0]];
      depth   <= depthM1;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqPulse,
  input  logic              nmiPulse,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              cpuReq,
  output logic [LVL_W-1:0]  cpuLevel,
  output logic [VEC_W-1:0]  cpuVector,
  input  logic              cpuAck,
  input  logic              cpuReti,
  output logic [LVL_W-1:0]  cpuMask,
  output logic              stackErr,
  output logic              dmaReq,
  output logic [VEC_W-1:0]  dmaVector,
  input  logic              dmaAck,
  input  logic              dmaEnd,
  input  logic [VEC_W-1:0]  dmaEndVec
);
  strobe_t          strobes;
  logic             winValid;
  logic [LVL_W-1:0] winLevel;
  logic [VEC_W-1:0] winVec;
  logic             winIsDma;

  prio_intc_dp u_dp (
    .clk, .rstN, .irqPulse, .nmiPulse, .regWe, .regAddr, .regWdata, .regRdata,
    .dmaEnd, .dmaEndVec, .strobes, .winValid, .winLevel, .winVec, .winIsDma
  );

  prio_intc_ctrl u_ctrl (
    .clk, .rstN, .winValid, .winLevel, .winIsDma, .cpuAck, .cpuReti, .dmaAck,
    .cpuReq, .dmaReq, .cpuMask, .stackErr, .strobes
  );

  assign cpuLevel  = cpuReq ? winLevel : '0;
  assign cpuVector = cpuReq ? winVec : '0;
  assign dmaVector = dmaReq ? winVec : '0;
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker
  import prio_intc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cpuReq,
  input logic [LVL_W-1:0] cpuLevel,
  input logic [VEC_W-1:0] cpuVector,
  input logic             cpuAck,
  input logic             cpuReti,
  input logic [LVL_W-1:0] cpuMask,
  input logic             stackErr,
  input logic             dmaReq
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  p_level_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (cpuLevel >= cpuMask || cpuLevel == LVL_MAX));

  p_no_zero_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> cpuLevel != '0);

  p_nmi_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuVector == '0) |-> cpuLevel == LVL_MAX);

  p_one_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuReq && dmaReq));

  p_mask_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuAck) |=> cpuMask ==
      (($past(cpuLevel) == LVL_MAX) ? LVL_MAX : $past(cpuLevel) + 1'b1));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!(cpuReq && cpuAck) && !cpuReti) |=> $stable(cpuMask));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);
endmodule

bind prio_intc prio_intc_checker u_chk (
  .clk, .rstN, .cpuReq, .cpuLevel, .cpuVector, .cpuAck, .cpuReti,
  .cpuMask, .stackErr, .dmaReq
);

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
module prio_intc_bench;
  import prio_intc_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic [NUM_CH-1:0] irqPulse;
  logic              nmiPulse, regWe, cpuAck, cpuReti, dmaAck, dmaEnd;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] regWdata, regRdata;
  logic [VEC_W-1:0]  dmaEndVec, cpuVector, dmaVector;
  logic              cpuReq, stackErr, dmaReq;
  logic [LVL_W-1:0]  cpuLevel, cpuMask;

  prio_intc u_prio_intc (.*);

  // next-cycle stimulus, applied at the falling edge
  logic [NUM_CH-1:0] nIrq;
  logic nNmi, nWe, nAck, nReti, nDack, nEnd;
  logic [ADDR_W-1:0] nAddr;
  logic [DATA_W-1:0] nWd;
  logic [VEC_W-1:0]  nEndVec;

  // reference model
  logic       mFlag [NUM_CH+1];
  logic [2:0] mPrio [NUM_CH];
  logic [5:0] mSlot [NUM_DMA];
  logic [2:0] mMask, mStk [STK_DEPTH];
  int         mDepth;
  logic       mErr;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic calcWin(output bit v, output int lvl, output int vec, output bit isDma);
    v = mFlag[0]; lvl = mFlag[0] ? 7 : 0; vec = 0; isDma = 0;
    for (int c = 0; c < NUM_CH; c++)
      if (mFlag[c+1] && mPrio[c] != 0 && mPrio[c] != 7 && int'(mPrio[c]) > lvl) begin
        v = 1; lvl = mPrio[c]; vec = c + 1;
      end
    for (int s = 0; s < NUM_DMA; s++)
      if (v && mSlot[s] != 0 && int'(mSlot[s]) == vec) isDma = 1;
  endtask

  function automatic int expRd(int a);
    int r = 0;
    if (a < NUM_CH/2)
      r = {mFlag[2*a+2], mPrio[2*a+1], mFlag[2*a+1], mPrio[2*a]};
    else if (a >= DMA_BASE && a < DMA_BASE + NUM_DMA)
      r = mSlot[a-DMA_BASE];
    return r;
  endfunction

  task automatic modelReset();
    for (int v = 0; v <= NUM_CH; v++) mFlag[v] = 0;
    for (int c = 0; c < NUM_CH; c++) mPrio[c] = 0;
    for (int s = 0; s < NUM_DMA; s++) mSlot[s] = 0;
    mMask = 0; mDepth = 0; mErr = 0;
  endtask

  task automatic idle();
    nIrq = '0; nNmi = 0; nWe = 0; nAck = 0; nReti = 0; nDack = 0; nEnd = 0;
    nAddr = '0; nWd = '0; nEndVec = '0;
  endtask

  task automatic step(string tag);
    bit v, d, req; int lvl, vec;
    bit clr [NUM_CH+1];
    string tq, tr, tv, td, tm, te;
    @(negedge clk);
    irqPulse = nIrq; nmiPulse = nNmi; regWe = nWe; regAddr = nAddr; regWdata = nWd;
    cpuAck = nAck; cpuReti = nReti; dmaAck = nDack; dmaEnd = nEnd; dmaEndVec = nEndVec;
    #1;
    calcWin(v, lvl, vec, d);
    req = v && !d && (lvl >= int'(mMask) || lvl == 7);
    tq = (tag != "") ? tag : "R4"; tr = (tag != "") ? tag : "R1";
    tv = (tag != "") ? tag : "R3"; td = (tag != "") ? tag : "R8";
    tm = (tag != "") ? tag : "R5"; te = (tag != "") ? tag : "R7";
    chk(tq, "cpuReq", cpuReq, req);
    chk(tv, "cpuLevel", cpuLevel, req ? lvl : 0);
    chk(tv, "cpuVector", cpuVector, req ? vec : 0);
    chk(td, "dmaReq", dmaReq, v && d);
    chk(td, "dmaVector", dmaVector, (v && d) ? vec : 0);
    chk(tm, "cpuMask", cpuMask, mMask);
    chk(te, "stackErr", stackErr, mErr);
    chk(tr, "regRdata", regRdata, expRd(regAddr));
    @(posedge clk);
    for (int i = 0; i <= NUM_CH; i++) clr[i] = 0;
    if (cpuAck && req) clr[vec] = 1;
    if (dmaAck && v && d) clr[vec] = 1;
    if (dmaEnd && dmaEndVec <= NUM_CH) clr[dmaEndVec] = 1;
    if (regWe && regAddr == CLR_ADDR && regWdata[5:0] <= NUM_CH) clr[regWdata[5:0]] = 1;
    for (int i = 0; i <= NUM_CH; i++) begin
      bit s = (i == 0) ? nmiPulse : irqPulse[i-1];
      mFlag[i] = (mFlag[i] && !clr[i]) || s;
    end
    if (regWe && regAddr < NUM_CH/2) begin
      mPrio[2*regAddr] = regWdata[2:0]; mPrio[2*regAddr+1] = regWdata[6:4];
    end
    if (regWe && regAddr >= DMA_BASE && regAddr < DMA_BASE + NUM_DMA)
      mSlot[regAddr-DMA_BASE] = regWdata[5:0];
    if (cpuAck && req) begin
      if (mDepth < STK_DEPTH) begin mStk[mDepth] = mMask; mDepth++; end
      else mErr = 1;
      mMask = (lvl == 7) ? 3'd7 : 3'(lvl + 1);
    end else if (cpuReti && mDepth > 0) begin
      mDepth--; mMask = mStk[mDepth];
    end
  endtask

  task automatic wr(int a, int d);
    idle(); nWe = 1; nAddr = 6'(a); nWd = 8'(d); step(""); idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    idle();
    irqPulse = '0; nmiPulse = 0; regWe = 0; regAddr = '0; regWdata = '0;
    cpuAck = 0; cpuReti = 0; dmaAck = 0; dmaEnd = 0; dmaEndVec = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    modelReset();
    @(negedge clk); rstN = 1;

    // R11: reset state across all register addresses
    for (int a = 0; a < 42; a++) begin idle(); nAddr = 6'(a); step("R11"); end

    // R1: pulse channels 0 and 1, read flags in bits 3/7; flag bits not writable
    idle(); nIrq[0] = 1; nIrq[1] = 1; step("");
    idle(); nAddr = 0; step("R1");
    wr(0, 8'h88); idle(); nAddr = 0; step("R1");
    // R2: channels 0/1 at levels 0 and 7 stay out of selection
    wr(0, 8'h70); idle(); step("R2");
    // clear them through the clear register (R9)
    wr(CLR_ADDR, 1); wr(CLR_ADDR, 2); idle(); nAddr = 0; step("R9");

    // R3: ties go to the lowest vector
    wr(2, 8'h44); wr(3, 8'h44);          // channels 4..7 at level 4
    idle(); nIrq[7] = 1; nIrq[5] = 1; step(""); idle(); step("R3");
    // R10: acknowledge vector 6 while channel 5 pulses again
    idle(); nAck = 1; nIrq[5] = 1; nAddr = 2; step("R10");
    idle(); nAddr = 2; step("R10");
    // R6: return restores mask 0
    idle(); nReti = 1; step(""); idle(); step("R6");
    idle(); nReti = 1; step(""); idle(); step("R6"); // empty stack: unchanged
    // R9: burst end clears vector 6, then vector 8
    idle(); nEnd = 1; nEndVec = 6; step(""); idle(); nEnd = 1; nEndVec = 8; step("");
    idle(); nAddr = 2; step("R9"); idle(); nAddr = 3; step("R9");

    // R8: slot routes vector 5 to DMA; dmaAck clears it
    wr(DMA_BASE + 3, 5); idle(); nIrq[4] = 1; step(""); idle(); step("R8");
    idle(); nDack = 1; step(""); idle(); nAddr = 2; step("R8");
    wr(DMA_BASE + 3, 0);

    // R7: nine nested watchdog acceptances overflow the stack
    for (int k = 0; k < 9; k++) begin
      idle(); nNmi = 1; step(""); idle(); nAck = 1; step("R5");
    end
    idle(); step("R7");
    for (int k = 0; k < 9; k++) begin idle(); nReti = 1; step("R6"); end
    idle(); step("R6");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      for (int c = 0; c < NUM_CH; c++) nIrq[c] = ($urandom % 48) == 0;
      nNmi  = ($urandom % 97) == 0;
      nAck  = ($urandom % 3) == 0;
      nReti = ($urandom % 4) == 0;
      nDack = ($urandom % 3) == 0;
      nEnd  = ($urandom % 10) == 0;
      nEndVec = 6'($urandom % 60);
      case ($urandom % 10)
        0: begin nWe = 1; nAddr = 6'($urandom % 26); nWd = 8'($urandom); end
        1: begin nWe = 1; nAddr = 6'(DMA_BASE + $urandom % 8); nWd = 8'($urandom % 53); end
        2: begin nWe = 1; nAddr = 6'(CLR_ADDR); nWd = 8'($urandom % 60); end
        default: nAddr = 6'($urandom % 42);
      endcase
      step("");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule